// File: doc/BRIEF.md
# Greedy Criticality-Aware Warp Scheduler

This block chooses which resident warp of a shader core issues next. For every warp it keeps two running counters: the instructions still left to execute and the cycles the warp has lost to stalls. From these and an externally measured average cycles-per-instruction figure it forms a lag estimate, the criticality. A warp that is far behind its siblings gets a high value, and the scheduler favours it so the slowest warp of a thread block catches up.

Selection is greedy. Once a warp is granted, it keeps the grant for as long as its ready bit stays high. Only when it drops out does the scheduler look at all ready warps again and take the one with the largest criticality. The surrounding pipeline loads each warp's instruction budget when the warp launches. It pulses an issue bit whenever the warp executes an instruction and raises a memory-stall bit while the warp waits for data. The grant comes out as an index and as a one-hot vector in the same cycle as the ready bits.

Top module: `gcws_top`

## Requirements
- R1: Reset clears every counter and the greedy selection. In the first cycle after reset with all warps ready, warp 0 is granted, because all criticalities are zero.
- R2: A load pulse sets the warp's remaining count to the load value and clears its stall count from the next cycle. A load wins over an issue pulse in the same cycle.
- R3: Criticality is the remaining count times the warp's average CPI input, plus its stall count. The CPI input is used as it stands in the current cycle.
- R4: Each issue pulse lowers the remaining count by one. The count stops at zero and never wraps.
- R5: The stall count rises by exactly one in each cycle where the warp has its memory-stall bit set, or is ready but not granted, and by one only when both hold. It stops at its all-ones value.
- R6: When a fresh choice is made, the grant goes to the ready warp with the highest criticality. Among equal values the lowest index wins.
- R7: If the warp granted in the previous grant cycle is still ready, it is granted again, whatever the criticalities are.
- R8: With no ready warp, grant_valid and grant_onehot are zero. The greedy selection is kept, so that warp is granted again once it becomes ready.
- R9: Only a ready warp is granted. grant_onehot has bit grant_idx set and no other bit, and is zero when nothing is granted.
- R10: With criticalities 5, 10, 3 and 7 on warps 0 to 3, each granted warp leaving the ready set in turn, the grants follow warps 1, 3, 0, 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ready | input | NUM_WARPS | Per-warp ready-to-issue bits |
| issued | input | NUM_WARPS | Per-warp instruction-executed pulses |
| mem_stall | input | NUM_WARPS | Per-warp memory-stall indications |
| load_en | input | NUM_WARPS | Per-warp instruction-budget load strobes |
| load_count | input | NUM_WARPS*ICNT_W | Budget for each warp, warp i in bits [i*ICNT_W +: ICNT_W] |
| avg_cpi | input | NUM_WARPS*CPI_W | Average CPI for each warp, warp i in bits [i*CPI_W +: CPI_W] |
| grant_valid | output | 1 | A warp is granted this cycle |
| grant_idx | output | $clog2(NUM_WARPS) | Index of the granted warp |
| grant_onehot | output | NUM_WARPS | One-hot form of the grant |

## Verification
The bench builds the block with four warps, 8-bit instruction budgets, 4-bit CPI and a 4-bit stall accumulator. The narrow accumulator brings its ceiling within twenty cycles, so a warp can be held in memory stall past saturation. The bench then shows that the stall count stopped at 15 and did not wrap to a small value. Four warps are enough to replay the 5/10/3/7 ordering. They also allow a third warp to take the greedy grant for one cycle, which forces a fresh comparison between two warps whose counters were changed by issue pulses.

// File: rtl/gcws_pkg.sv
package gcws_pkg;

    // How the grant of the current cycle was decided
    typedef enum logic [1:0] {
        PICK_NONE = 2'd0,
        PICK_HOLD = 2'd1,
        PICK_BEST = 2'd2
    } pick_e;

endpackage

// File: rtl/gcws_warp_track.sv
module gcws_warp_track #(
    parameter int ICNT_W  = 16,
    parameter int CPI_W   = 4,
    parameter int STALL_W = 12,
    parameter int CRIT_W  = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [ICNT_W-1:0] load_cnt,
    input  logic              issue,
    input  logic              mem_stall,
    input  logic              waiting,
    input  logic [CPI_W-1:0]  cpi,
    output logic [CRIT_W-1:0] crit
);

    typedef struct packed {
        logic [ICNT_W-1:0]  rem;
        logic [STALL_W-1:0] stall;
    } trk_t;

    trk_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_en) begin
            st_d.rem   = load_cnt;
            st_d.stall = '0;
        end else begin
            if (issue && (st_q.rem != '0)) begin
                st_d.rem = st_q.rem - 1'b1;
            end
            if ((mem_stall || waiting) && (st_q.stall != '1)) begin
                st_d.stall = st_q.stall + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // lag estimate: remaining work scaled by cost per instruction, plus lost cycles
    always_comb begin
        crit = (CRIT_W'(st_q.rem) * CRIT_W'(cpi)) + CRIT_W'(st_q.stall);
    end

    a_r2_load_sets: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (st_q.rem == $past(load_cnt)) && (st_q.stall == '0));

    a_r4_floor_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !load_en && (st_q.rem == '0)) |=> (st_q.rem == '0));

    a_r5_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && (st_q.stall == '1)) |=> (st_q.stall == '1));

    a_r5_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && (mem_stall || waiting) && (st_q.stall != '1))
            |=> (st_q.stall == $past(st_q.stall) + 1'b1));

endmodule

// File: rtl/gcws_argmax.sv
module gcws_argmax #(
    parameter int NUM    = 8,
    parameter int CRIT_W = 21,
    parameter int IDX_W  = 3
) (
    input  logic [NUM*CRIT_W-1:0] crit_flat,
    input  logic [NUM-1:0]        cand,
    output logic [IDX_W-1:0]      best_idx,
    output logic                  best_vld
);

    logic [CRIT_W-1:0] best_c;

    // linear scan; strict compare keeps the lowest index on ties
    always_comb begin
        best_idx = '0;
        best_vld = 1'b0;
        best_c   = '0;
        for (int i = 0; i < NUM; i++) begin
            if (cand[i] && (!best_vld || (crit_flat[i*CRIT_W +: CRIT_W] > best_c))) begin
                best_vld = 1'b1;
                best_idx = IDX_W'(i);
                best_c   = crit_flat[i*CRIT_W +: CRIT_W];
            end
        end
    end

endmodule

// File: rtl/gcws_pick_ctrl.sv
module gcws_pick_ctrl
    import gcws_pkg::*;
#(
    parameter int NUM   = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NUM-1:0]   ready,
    input  logic [IDX_W-1:0] best_idx,
    input  logic             best_vld,
    output logic             grant_vld,
    output logic [IDX_W-1:0] grant_idx,
    output logic [NUM-1:0]   grant_oh
);

    typedef struct packed {
        logic [IDX_W-1:0] cur;
        logic             cur_vld;
    } sel_t;

    sel_t  sel_d, sel_q;
    pick_e pick;

    always_comb begin
        sel_d     = sel_q;
        pick      = PICK_NONE;
        grant_vld = 1'b0;
        grant_idx = sel_q.cur;
        if (sel_q.cur_vld && ready[sel_q.cur]) begin
            pick = PICK_HOLD;
        end else if (best_vld) begin
            pick = PICK_BEST;
        end
        case (pick)
            PICK_HOLD: begin
                grant_vld = 1'b1;
                grant_idx = sel_q.cur;
            end
            PICK_BEST: begin
                grant_vld = 1'b1;
                grant_idx = best_idx;
            end
            default: begin
                grant_vld = 1'b0;
                grant_idx = sel_q.cur;
            end
        endcase
        if (grant_vld) begin
            sel_d.cur     = grant_idx;
            sel_d.cur_vld = 1'b1;
        end
    end

    always_comb begin
        grant_oh = '0;
        for (int i = 0; i < NUM; i++) begin
            grant_oh[i] = grant_vld && (grant_idx == IDX_W'(i));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else begin
            sel_q <= sel_d;
        end
    end

    a_r7_greedy_keep: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld |=> (!ready[$past(grant_idx)] ||
                       (grant_vld && (grant_idx == $past(grant_idx)))));

    a_r8_idle_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (ready == '0) |-> (!grant_vld && (grant_oh == '0)));

    a_r8_idle_keeps_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (ready == '0) |=> (sel_q == $past(sel_q)));

    a_r9_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_oh) && (grant_vld == (grant_oh != '0)));

endmodule

// File: rtl/gcws_top.sv
module gcws_top #(
    parameter int NUM_WARPS = 8,
    parameter int ICNT_W    = 16,
    parameter int CPI_W     = 4,
    parameter int STALL_W   = 12,
    localparam int IDX_W    = $clog2(NUM_WARPS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_WARPS-1:0]        ready,
    input  logic [NUM_WARPS-1:0]        issued,
    input  logic [NUM_WARPS-1:0]        mem_stall,
    input  logic [NUM_WARPS-1:0]        load_en,
    input  logic [NUM_WARPS*ICNT_W-1:0] load_count,
    input  logic [NUM_WARPS*CPI_W-1:0]  avg_cpi,
    output logic                        grant_valid,
    output logic [IDX_W-1:0]            grant_idx,
    output logic [NUM_WARPS-1:0]        grant_onehot
);

    localparam int PROD_W = ICNT_W + CPI_W;
    localparam int CRIT_W = ((PROD_W > STALL_W) ? PROD_W : STALL_W) + 1;

    logic [NUM_WARPS*CRIT_W-1:0] crit_flat;
    logic [CRIT_W-1:0]           crit_arr [NUM_WARPS];
    logic [NUM_WARPS-1:0]        waiting;
    logic [IDX_W-1:0]            best_idx;
    logic                        best_vld;

    // a ready warp that loses arbitration is losing time to the scheduler
    always_comb begin
        waiting = ready & ~grant_onehot;
    end

    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
        gcws_warp_track #(
            .ICNT_W (ICNT_W),
            .CPI_W  (CPI_W),
            .STALL_W(STALL_W),
            .CRIT_W (CRIT_W)
        ) u_trk (
            .clk      (clk),
            .rst_n    (rst_n),
            .load_en  (load_en[w]),
            .load_cnt (load_count[w*ICNT_W +: ICNT_W]),
            .issue    (issued[w]),
            .mem_stall(mem_stall[w]),
            .waiting  (waiting[w]),
            .cpi      (avg_cpi[w*CPI_W +: CPI_W]),
            .crit     (crit_flat[w*CRIT_W +: CRIT_W])
        );

        assign crit_arr[w] = crit_flat[w*CRIT_W +: CRIT_W];

        a_r6_best_is_max: assert property (@(posedge clk) disable iff (!rst_n)
            (best_vld && ready[w]) |-> (crit_arr[w] <= crit_arr[best_idx]));

        a_r6_tie_lowest: assert property (@(posedge clk) disable iff (!rst_n)
            (best_vld && ready[w] && (IDX_W'(w) < best_idx))
                |-> (crit_arr[w] < crit_arr[best_idx]));
    end

    gcws_argmax #(
        .NUM   (NUM_WARPS),
        .CRIT_W(CRIT_W),
        .IDX_W (IDX_W)
    ) u_argmax (
        .crit_flat(crit_flat),
        .cand     (ready),
        .best_idx (best_idx),
        .best_vld (best_vld)
    );

    gcws_pick_ctrl #(
        .NUM  (NUM_WARPS),
        .IDX_W(IDX_W)
    ) u_pick (
        .clk      (clk),
        .rst_n    (rst_n),
        .ready    (ready),
        .best_idx (best_idx),
        .best_vld (best_vld),
        .grant_vld(grant_valid),
        .grant_idx(grant_idx),
        .grant_oh (grant_onehot)
    );

    a_r9_grant_ready: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> ready[grant_idx]);

endmodule

// File: tb/sim_gcws_top.sv
module sim_gcws_top;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 4;
    localparam int ICNT_W     = 8;
    localparam int CPI_W      = 4;
    localparam int STALL_W    = 4;
    localparam int IDX_W      = $clog2(N);

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic [N-1:0]           rdy = '0, iss = '0, mst = '0, ldv = '0;
    logic [ICNT_W-1:0]      ldc [N];
    logic [CPI_W-1:0]       cpi [N];
    logic [N*ICNT_W-1:0]    ldc_flat;
    logic [N*CPI_W-1:0]     cpi_flat;
    logic                   grant_valid;
    logic [IDX_W-1:0]       grant_idx;
    logic [N-1:0]           grant_onehot;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic  v;
        int    idx;
        string tag;
    } exp_t;

    exp_t sbq[$];
    event smp_ev;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            ldc_flat[i*ICNT_W +: ICNT_W] = ldc[i];
            cpi_flat[i*CPI_W +: CPI_W]   = cpi[i];
        end
    end

    gcws_top #(
        .NUM_WARPS(N),
        .ICNT_W   (ICNT_W),
        .CPI_W    (CPI_W),
        .STALL_W  (STALL_W)
    ) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .ready       (rdy),
        .issued      (iss),
        .mem_stall   (mst),
        .load_en     (ldv),
        .load_count  (ldc_flat),
        .avg_cpi     (cpi_flat),
        .grant_valid (grant_valid),
        .grant_idx   (grant_idx),
        .grant_onehot(grant_onehot)
    );

    // monitor: pops expected grants and compares with the outputs
    initial begin
        forever begin
            @(smp_ev);
            while (sbq.size() > 0) begin
                exp_t e;
                logic [N-1:0] exp_oh;
                e = sbq.pop_front();
                checks++;
                if ((grant_valid !== e.v) || (e.v && (grant_idx !== IDX_W'(e.idx)))) begin
                    fails++;
                    $display("FAIL %s: actual valid=%0b idx=%0d expected valid=%0b idx=%0d",
                             e.tag, grant_valid, grant_idx, e.v, e.idx);
                end
                exp_oh = e.v ? (N'(1) << e.idx) : '0;
                checks++;
                if (grant_onehot !== exp_oh) begin
                    fails++;
                    $display("FAIL R9 onehot (%s): actual=%b expected=%b",
                             e.tag, grant_onehot, exp_oh);
                end
            end
        end
    end

    task automatic step(input logic [N-1:0] r, input logic [N-1:0] i,
                        input logic [N-1:0] m, input logic [N-1:0] l,
                        input logic ev, input int eidx, input string tag);
        exp_t e;
        @(negedge clk);
        rdy = r; iss = i; mst = m; ldv = l;
        #1;
        e.v = ev; e.idx = eidx; e.tag = tag;
        sbq.push_back(e);
        -> smp_ev;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        rdy = '0; iss = '0; mst = '0; ldv = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic set_loads(input int a, input int b, input int c, input int d);
        ldc[0] = ICNT_W'(a); ldc[1] = ICNT_W'(b); ldc[2] = ICNT_W'(c); ldc[3] = ICNT_W'(d);
    endtask

    task automatic set_cpi(input int a, input int b, input int c, input int d);
        cpi[0] = CPI_W'(a); cpi[1] = CPI_W'(b); cpi[2] = CPI_W'(c); cpi[3] = CPI_W'(d);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        fails++;
        $display("FAIL watchdog (all requirements): actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        set_loads(0, 0, 0, 0);
        set_cpi(1, 1, 1, 1);

        // R1 / R8: reset state
        do_reset();
        step(4'b0000, 0, 0, 0, 1'b0, 0, "R8 idle after reset");
        step(4'b1111, 0, 0, 0, 1'b1, 0, "R1 zeroed counters grant warp 0");

        // R10 / R7 / R8: ordering example
        do_reset();
        set_loads(5, 10, 3, 7);
        step(4'b0000, 0, 0, 4'b1111, 1'b0, 0, "R2 load cycle idle");
        step(4'b1111, 4'b0010, 0, 0, 1'b1, 1, "R10 first pick warp 1");
        step(4'b1111, 4'b0010, 0, 0, 1'b1, 1, "R7 keep warp 1");
        step(4'b1111, 4'b0010, 0, 0, 1'b1, 1, "R7 keep warp 1 though warp 3 leads");
        step(4'b1101, 0, 0, 0, 1'b1, 3, "R10 second pick warp 3");
        step(4'b0101, 0, 0, 0, 1'b1, 0, "R10 third pick warp 0");
        step(4'b0100, 0, 0, 0, 1'b1, 2, "R10 fourth pick warp 2");
        step(4'b0000, 0, 0, 0, 1'b0, 0, "R8 no ready no grant");
        step(4'b1111, 0, 0, 0, 1'b1, 2, "R8 selection held through idle");

        // R3: CPI scaling
        do_reset();
        set_loads(3, 10, 0, 0);
        set_cpi(4, 1, 1, 1);
        step(4'b0000, 0, 0, 4'b0011, 1'b0, 0, "R2 load cycle idle");
        step(4'b0011, 0, 0, 0, 1'b1, 0, "R3 3x4 beats 10x1");
        do_reset();
        set_cpi(3, 1, 1, 1);
        step(4'b0000, 0, 0, 4'b0011, 1'b0, 0, "R2 load cycle idle");
        step(4'b0011, 0, 0, 0, 1'b1, 1, "R3 3x3 loses to 10x1");
        set_cpi(1, 1, 1, 1);

        // R6: tie and ready filtering
        do_reset();
        set_loads(2, 6, 6, 1);
        step(4'b0000, 0, 0, 4'b1111, 1'b0, 0, "R2 load cycle idle");
        step(4'b0110, 0, 0, 0, 1'b1, 1, "R6 tie goes to lower index");
        step(4'b1001, 0, 0, 0, 1'b1, 0, "R6 best among ready only");

        // R4: decrement
        do_reset();
        set_loads(6, 5, 0, 0);
        step(4'b0000, 0, 0, 4'b0111, 1'b0, 0, "R2 load cycle idle");
        step(4'b0001, 4'b0001, 0, 0, 1'b1, 0, "R4 issue warp 0");
        step(4'b0001, 4'b0001, 0, 0, 1'b1, 0, "R4 issue warp 0 again");
        step(4'b0100, 0, 0, 0, 1'b1, 2, "R4 hand grant to warp 2");
        step(4'b0011, 0, 0, 0, 1'b1, 1, "R4 decremented warp 0 loses");

        // R4: floor at zero
        do_reset();
        set_loads(1, 1, 0, 0);
        step(4'b0000, 0, 0, 4'b0111, 1'b0, 0, "R2 load cycle idle");
        for (int k = 0; k < 3; k++) step(4'b0001, 4'b0001, 0, 0, 1'b1, 0, "R4 issue past zero");
        step(4'b0100, 0, 0, 0, 1'b1, 2, "R4 hand grant to warp 2");
        step(4'b0011, 0, 0, 0, 1'b1, 1, "R4 count stopped at zero");

        // R2: load clears stall
        do_reset();
        set_loads(0, 0, 0, 0);
        step(4'b0000, 0, 0, 4'b0001, 1'b0, 0, "R2 load cycle idle");
        for (int k = 0; k < 5; k++) step(4'b0000, 0, 4'b0001, 0, 1'b0, 0, "R5 memory stall idle");
        set_loads(1, 3, 0, 0);
        step(4'b0000, 0, 0, 4'b0011, 1'b0, 0, "R2 reload idle");
        step(4'b0011, 0, 0, 0, 1'b1, 1, "R2 reload cleared stall");

        // R2: load wins over issue
        do_reset();
        set_loads(4, 4, 0, 0);
        step(4'b0000, 4'b0001, 0, 4'b0011, 1'b0, 0, "R2 load with issue idle");
        step(4'b0011, 0, 0, 0, 1'b1, 0, "R2 load beat issue tie to warp 0");

        // R5: memory stall accrual
        do_reset();
        set_loads(2, 4, 0, 0);
        step(4'b0000, 0, 0, 4'b0011, 1'b0, 0, "R2 load cycle idle");
        for (int k = 0; k < 3; k++) step(4'b0000, 0, 4'b0001, 0, 1'b0, 0, "R5 memory stall idle");
        step(4'b0011, 0, 0, 0, 1'b1, 0, "R5 stall cycles raise warp 0");

        // R5: scheduler-induced wait accrual
        do_reset();
        set_loads(5, 4, 6, 0);
        step(4'b0000, 0, 0, 4'b0111, 1'b0, 0, "R2 load cycle idle");
        for (int k = 0; k < 3; k++) step(4'b0011, 0, 0, 0, 1'b1, 0, "R7 warp 0 held");
        step(4'b0110, 0, 0, 0, 1'b1, 1, "R5 waiting raised warp 1");

        // R5: stall and wait together count once
        do_reset();
        set_loads(9, 4, 8, 0);
        step(4'b0000, 0, 0, 4'b0111, 1'b0, 0, "R2 load cycle idle");
        for (int k = 0; k < 3; k++) step(4'b0011, 0, 4'b0010, 0, 1'b1, 0, "R7 warp 0 held");
        step(4'b0110, 0, 0, 0, 1'b1, 2, "R5 single step per cycle");

        // R5: ceiling
        do_reset();
        set_loads(0, 14, 0, 0);
        step(4'b0000, 0, 0, 4'b0011, 1'b0, 0, "R2 load cycle idle");
        for (int k = 0; k < 20; k++) step(4'b0000, 0, 4'b0001, 0, 1'b0, 0, "R5 stall toward ceiling");
        step(4'b0011, 0, 0, 0, 1'b1, 0, "R5 stall held at 15");

        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule